// File: doc/BRIEF.md
# Staggered Double-Rate Split Adder

This block is a 32-bit integer adder built from two 16-bit slices. It runs on a fast clock at twice the main pipeline frequency, and the two halves of each sum are computed one fast cycle apart. The low slice adds bits 15:0 in the first fast cycle and registers its carry. The high slice adds bits 31:16 in the next fast cycle, using that registered carry.

The low half of a sum is ready one fast cycle after the operation is accepted, and the block presents it on an early-forwarding output. A following operation can name the previous result as its first operand. Its low slice then takes the previous low half while the previous high half is still being computed, and its high slice takes the previous high half one fast cycle later. Dependent adds therefore issue on every fast cycle, which is every half main cycle. The full 32-bit sum, its carry out of bit 31 and the operation's tag appear two fast cycles after acceptance, which is one main cycle.

Operands enter through a valid/ready port and results leave through another. An operation is accepted on a fast edge where `in_valid` and `in_ready` are both high. A result is taken on an edge where `out_valid` and `out_ready` are both high. A held result stalls the whole adder: `in_ready = !out_valid || out_ready`. While stalled, both slices freeze, so no in-flight half is lost or reordered.

Top module: `staggered_adder`

## Requirements
- R1: After reset, `out_valid` and `fwd_lo_valid` are 0, and `in_ready` is 1.
- R2: For an accepted operation, `out_sum` equals (A + B) mod 2^32. With `out_ready` held high, it appears with `out_valid` two fast cycles after acceptance.
- R3: One fast cycle after acceptance, with no stall in between, `fwd_lo_valid` is 1, `fwd_lo` holds bits 15:0 of the sum, and `fwd_tag` holds the operation's tag.
- R4: The carry out of bit 15 reaches the high slice, and `out_carry` is bit 32 of the 33-bit sum A + B.
- R5: When `in_chain` is 1, `in_a` is ignored and A is the full sum of the previously accepted operation. Dependent operations may be accepted on consecutive fast cycles.
- R6: Whenever `out_ready` is 1, `in_ready` is 1, so one operation can be accepted every fast cycle.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_sum`, `out_carry` and `out_tag` stay unchanged on the next edge.
- R8: Results leave in acceptance order, and each carries the `in_tag` given with its own operands.
- R9: Chaining refers to the previously accepted operation even when bubbles or stalls separate the two operations.
- R10: For a chained operation that is the first accepted since reset, the previous sum is taken as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (twice the main clock) |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this edge |
| in_chain | input | 1 | Use previous sum as operand A |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B |
| in_tag | input | 4 | Operation tag |
| fwd_lo_valid | output | 1 | Early low half is valid |
| fwd_lo | output | 16 | Early low half of the sum |
| fwd_tag | output | 4 | Tag of the early low half |
| out_valid | output | 1 | Full result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_sum | output | 32 | Full sum |
| out_carry | output | 1 | Carry out of bit 31 |
| out_tag | output | 4 | Tag of the full result |

## Verification
The early low half is due one fast cycle after acceptance, and the full sum two fast cycles after acceptance. A stall adds one cycle to both for each stalled edge. The bench drives and samples one nanosecond after each falling edge. It tracks which operation sits in each stage and checks the forwarded half against the operation accepted on the previous enabled edge. Each result is matched against a queue of arithmetically computed sums, and the exact two-cycle latency is required whenever no stall occurred between acceptance and delivery. A held result is compared with its own value from the previous sample.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
  // Where the low slice takes operand A from
  typedef enum logic [1:0] {
    SRC_PORT  = 2'd0,
    SRC_STAGE = 2'd1,
    SRC_LAST  = 2'd2
  } lo_src_e;

  function automatic lo_src_e pick_lo_src(input logic chain, input logic stage_valid);
    if (!chain)           return SRC_PORT;
    else if (stage_valid) return SRC_STAGE;
    else                  return SRC_LAST;
  endfunction
endpackage

// File: rtl/dsa_slice_add.sv
module dsa_slice_add #(
  parameter int SW = 16
) (
  input  logic [SW-1:0] a_i,
  input  logic [SW-1:0] b_i,
  input  logic          c_i,
  output logic [SW-1:0] s_o,
  output logic          c_o
);
  logic [SW:0] total;

  always_comb begin
    total = {1'b0, a_i} + {1'b0, b_i} + {{SW{1'b0}}, c_i};
    s_o   = total[SW-1:0];
    c_o   = total[SW];
  end
endmodule

// File: rtl/dsa_lo_stage.sv
module dsa_lo_stage
  import dsa_pkg::*;
#(
  parameter int W     = 32,
  parameter int TAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              acc_i,
  input  logic              chain_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic [W-1:0]      last_i,
  output logic              valid_o,
  output logic              chain_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [W/2-1:0]    lo_o,
  output logic              carry_o,
  output logic [W-W/2-1:0]  a_hi_o,
  output logic [W-W/2-1:0]  b_hi_o
);
  localparam int HW = W / 2;

  lo_src_e      src;
  logic [HW-1:0] a_lo;
  logic [HW-1:0] lo_sum;
  logic          lo_cy;

  always_comb begin
    src = pick_lo_src(chain_i, valid_o);
    case (src)
      SRC_STAGE: a_lo = lo_o;
      SRC_LAST:  a_lo = last_i[HW-1:0];
      default:   a_lo = a_i[HW-1:0];
    endcase
  end

  dsa_slice_add #(.SW(HW)) lo_slice_i (
    .a_i (a_lo),
    .b_i (b_i[HW-1:0]),
    .c_i (1'b0),
    .s_o (lo_sum),
    .c_o (lo_cy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      chain_o <= 1'b0;
      tag_o   <= '0;
      lo_o    <= '0;
      carry_o <= 1'b0;
      a_hi_o  <= '0;
      b_hi_o  <= '0;
    end else if (en_i) begin
      valid_o <= acc_i;
      if (acc_i) begin
        chain_o <= chain_i;
        tag_o   <= tag_i;
        lo_o    <= lo_sum;
        carry_o <= lo_cy;
        a_hi_o  <= a_i[W-1:HW];
        b_hi_o  <= b_i[W-1:HW];
      end
    end
  end
endmodule

// File: rtl/dsa_hi_stage.sv
module dsa_hi_stage #(
  parameter int W     = 32,
  parameter int TAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              lvalid_i,
  input  logic              lchain_i,
  input  logic [TAG_W-1:0]  ltag_i,
  input  logic [W/2-1:0]    llo_i,
  input  logic              lcarry_i,
  input  logic [W-W/2-1:0]  la_hi_i,
  input  logic [W-W/2-1:0]  lb_hi_i,
  output logic              valid_o,
  output logic [W-1:0]      sum_o,
  output logic              carry_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [W-1:0]      last_o
);
  localparam int HW   = W / 2;
  localparam int HI_W = W - HW;

  logic [HI_W-1:0] a_hi;
  logic [HI_W-1:0] hi_sum;
  logic            hi_cy;

  // high half of the previous sum has just landed in last_o
  always_comb a_hi = lchain_i ? last_o[W-1:HW] : la_hi_i;

  dsa_slice_add #(.SW(HI_W)) hi_slice_i (
    .a_i (a_hi),
    .b_i (lb_hi_i),
    .c_i (lcarry_i),
    .s_o (hi_sum),
    .c_o (hi_cy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      sum_o   <= '0;
      carry_o <= 1'b0;
      tag_o   <= '0;
      last_o  <= '0;
    end else if (en_i) begin
      valid_o <= lvalid_i;
      if (lvalid_i) begin
        sum_o   <= {hi_sum, llo_i};
        carry_o <= hi_cy;
        tag_o   <= ltag_i;
        last_o  <= {hi_sum, llo_i};
      end
    end
  end
endmodule

// File: rtl/staggered_adder.sv
module staggered_adder #(
  parameter int W     = 32,
  parameter int TAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_chain,
  input  logic [W-1:0]      in_a,
  input  logic [W-1:0]      in_b,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              fwd_lo_valid,
  output logic [W/2-1:0]    fwd_lo,
  output logic [TAG_W-1:0]  fwd_tag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [W-1:0]      out_sum,
  output logic              out_carry,
  output logic [TAG_W-1:0]  out_tag
);
  localparam int HW   = W / 2;
  localparam int HI_W = W - HW;

  logic              en;
  logic              acc;
  logic              l_valid;
  logic              l_chain;
  logic [TAG_W-1:0]  l_tag;
  logic [HW-1:0]     l_lo;
  logic              l_carry;
  logic [HI_W-1:0]   l_a_hi;
  logic [HI_W-1:0]   l_b_hi;
  logic [W-1:0]      last_sum;

  always_comb begin
    en       = !out_valid || out_ready;
    in_ready = en;
    acc      = in_valid && en;
  end

  dsa_lo_stage #(.W(W), .TAG_W(TAG_W)) lo_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en),
    .acc_i   (acc),
    .chain_i (in_chain),
    .tag_i   (in_tag),
    .a_i     (in_a),
    .b_i     (in_b),
    .last_i  (last_sum),
    .valid_o (l_valid),
    .chain_o (l_chain),
    .tag_o   (l_tag),
    .lo_o    (l_lo),
    .carry_o (l_carry),
    .a_hi_o  (l_a_hi),
    .b_hi_o  (l_b_hi)
  );

  dsa_hi_stage #(.W(W), .TAG_W(TAG_W)) hi_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en),
    .lvalid_i (l_valid),
    .lchain_i (l_chain),
    .ltag_i   (l_tag),
    .llo_i    (l_lo),
    .lcarry_i (l_carry),
    .la_hi_i  (l_a_hi),
    .lb_hi_i  (l_b_hi),
    .valid_o  (out_valid),
    .sum_o    (out_sum),
    .carry_o  (out_carry),
    .tag_o    (out_tag),
    .last_o   (last_sum)
  );

  always_comb begin
    fwd_lo_valid = l_valid;
    fwd_lo       = l_lo;
    fwd_tag      = l_tag;
  end
endmodule

// File: rtl/dsa_adder_chk.sv
module dsa_adder_chk #(
  parameter int W     = 32,
  parameter int TAG_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_chain,
  input logic [W-1:0]      in_a,
  input logic [W-1:0]      in_b,
  input logic              fwd_lo_valid,
  input logic [W/2-1:0]    fwd_lo,
  input logic [TAG_W-1:0]  fwd_tag,
  input logic              out_valid,
  input logic              out_ready,
  input logic [W-1:0]      out_sum,
  input logic              out_carry,
  input logic [TAG_W-1:0]  out_tag
);
  localparam int HW = W / 2;

  p_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) &&
                                   $stable(out_carry) && $stable(out_tag)));

  p_lowhalf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_chain) |=>
      (fwd_lo_valid && fwd_lo == ($past(in_a[HW-1:0]) + $past(in_b[HW-1:0]))));

  p_stage_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_lo_valid && in_ready) |=>
      (out_valid && out_sum[HW-1:0] == $past(fwd_lo) && out_tag == $past(fwd_tag)));

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwd_lo_valid && in_ready) |=> !out_valid);
endmodule

bind staggered_adder dsa_adder_chk #(.W(W), .TAG_W(TAG_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_chain     (in_chain),
  .in_a         (in_a),
  .in_b         (in_b),
  .fwd_lo_valid (fwd_lo_valid),
  .fwd_lo       (fwd_lo),
  .fwd_tag      (fwd_tag),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_sum      (out_sum),
  .out_carry    (out_carry),
  .out_tag      (out_tag)
);

// File: tb/staggered_adder_tb_top.sv
module staggered_adder_tb_top;
  localparam int W     = 32;
  localparam int TAG_W = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid, in_ready, in_chain;
  logic [W-1:0]     in_a, in_b;
  logic [TAG_W-1:0] in_tag;
  logic             fwd_lo_valid;
  logic [15:0]      fwd_lo;
  logic [TAG_W-1:0] fwd_tag;
  logic             out_valid, out_ready, out_carry;
  logic [W-1:0]     out_sum;
  logic [TAG_W-1:0] out_tag;

  always #2 clk = ~clk;

  staggered_adder #(.W(W), .TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_chain(in_chain), .in_a(in_a), .in_b(in_b), .in_tag(in_tag),
    .fwd_lo_valid(fwd_lo_valid), .fwd_lo(fwd_lo), .fwd_tag(fwd_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum),
    .out_carry(out_carry), .out_tag(out_tag)
  );

  int total = 0;
  int bad   = 0;
  int step_n = 0;
  int stall_n = 0;

  // expected-result queue
  logic [W:0]       q_s [64];
  logic [TAG_W-1:0] q_t [64];
  int               q_st [64];
  int               q_cy [64];
  int wr = 0, rd = 0;

  logic [W-1:0]     last_m;
  logic             exp_fv;
  logic [15:0]      exp_fl;
  logic [TAG_W-1:0] exp_ft;
  logic             hold_pend;
  logic [W-1:0]     hold_sum;
  logic [TAG_W-1:0] hold_tag;
  logic             hold_cy;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (step %0d)", req, act, exp, step_n);
    end
  endtask

  task automatic model_reset();
    last_m = '0; exp_fv = 1'b0; exp_fl = '0; exp_ft = '0;
    hold_pend = 1'b0; wr = 0; rd = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_chain = 1'b0; in_a = '0; in_b = '0;
    in_tag = '0; out_ready = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cycle(input logic v, input logic ch, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic [TAG_W-1:0] tg,
                       input logic ordy);
    logic [W:0] s;
    logic [W-1:0] ae;
    @(negedge clk);
    in_valid = v; in_chain = ch; in_a = a; in_b = b; in_tag = tg; out_ready = ordy;
    #1;
    step_n++;
    // early low half (R3)
    if (exp_fv) begin
      chk("R3 fwd_valid", {63'd0, fwd_lo_valid}, 64'd1);
      chk("R3 fwd_lo", {48'd0, fwd_lo}, {48'd0, exp_fl});
      chk("R3 fwd_tag", {60'd0, fwd_tag}, {60'd0, exp_ft});
    end else begin
      chk("R3 fwd_idle", {63'd0, fwd_lo_valid}, 64'd0);
    end
    // held result stability (R7)
    if (hold_pend) begin
      chk("R7 hold_valid", {63'd0, out_valid}, 64'd1);
      chk("R7 hold_sum", {32'd0, out_sum}, {32'd0, hold_sum});
      chk("R7 hold_tag", {59'd0, out_carry, out_tag}, {59'd0, hold_cy, hold_tag});
    end
    hold_pend = out_valid && !out_ready;
    hold_sum = out_sum; hold_tag = out_tag; hold_cy = out_carry;
    if (out_ready) chk("R6 ready", {63'd0, in_ready}, 64'd1);
    // result delivery (R2 R4 R8)
    if (out_valid && out_ready) begin
      if (rd == wr) begin
        chk("R8 unexpected result", 64'd1, 64'd0);
      end else begin
        chk("R2 R4 sum", {31'd0, out_carry, out_sum}, {31'd0, q_s[rd % 64]});
        chk("R8 tag", {60'd0, out_tag}, {60'd0, q_t[rd % 64]});
        if (q_st[rd % 64] == stall_n)
          chk("R2 latency", 64'(step_n - q_cy[rd % 64]), 64'd2);
        rd++;
      end
    end
    // model update on an enabled edge
    if (in_ready) begin
      exp_fv = v;
      if (v) begin
        ae = ch ? last_m : a;
        s = {1'b0, ae} + {1'b0, b};
        exp_fl = s[15:0]; exp_ft = tg;
        last_m = s[W-1:0];
        q_s[wr % 64] = s; q_t[wr % 64] = tg;
        q_st[wr % 64] = stall_n; q_cy[wr % 64] = step_n;
        wr++;
      end
    end else begin
      stall_n++;
    end
  endtask

  function automatic logic [W-1:0] corner(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h0000_FFFF;
      3: return 32'h0001_0000;
      4: return 32'h7FFF_FFFF;
      5: return 32'h8000_0000;
      6: return 32'hFFFF_FFFF;
      default: return 32'h0001_FFFF;
    endcase
  endfunction

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog R2 act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 out_valid", {63'd0, out_valid}, 64'd0);
    chk("R1 fwd_valid", {63'd0, fwd_lo_valid}, 64'd0);
    chk("R1 in_ready", {63'd0, in_ready}, 64'd1);

    // corner sweep, back to back (R2 R4 R6 R8)
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        cycle(1'b1, 1'b0, corner(i), corner(j), TAG_W'(i * 8 + j), 1'b1);

    // arithmetic pattern sweep over carry boundaries (R4)
    for (int k = 0; k < 256; k++)
      cycle(1'b1, 1'b0, 32'(k) * 32'h0101_0101 ^ (32'(k) << 13),
            32'hFFFF_FFFF - 32'(k) * 32'h0003_0101, TAG_W'(k), 1'b1);

    // dependent chain of 16, every fast cycle (R5)
    cycle(1'b1, 1'b0, 32'h0000_FFF0, 32'h0000_0008, 4'h0, 1'b1);
    for (int k = 1; k < 16; k++)
      cycle(1'b1, 1'b1, 32'hDEAD_BEEF, 32'h0000_FFFF * 32'(k) + 32'(k), TAG_W'(k), 1'b1);

    // bubbles, stalls and chains mixed (R7 R9)
    for (int k = 0; k < 300; k++)
      cycle((k % 3) != 2, (k % 4) == 1, 32'(k) * 32'h9E37_79B9, 32'hC000_7FFF + 32'(k) * 32'h0001_1111,
            TAG_W'(k), (k % 5) < 3);

    for (int k = 0; k < 6; k++) cycle(1'b0, 1'b0, '0, '0, '0, 1'b1);
    chk("R8 drained", 64'(wr - rd), 64'd0);

    // first chained op after reset sees 0 (R10)
    do_reset();
    cycle(1'b1, 1'b1, 32'hDEAD_BEEF, 32'h0000_0005, 4'hA, 1'b1);
    cycle(1'b1, 1'b1, 32'h1234_5678, 32'hFFFF_FFFC, 4'hB, 1'b1);
    for (int k = 0; k < 4; k++) cycle(1'b0, 1'b0, '0, '0, '0, 1'b1);
    chk("R10 drained", 64'(wr - rd), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule